// File: doc/BRIEF.md
# Table-Encoded Gated Clock Divider

This block produces a divided clock from one fast parent clock. Every register in it runs on the parent clock, and the divided output is itself a register output, so it is free of combinational glitches. Software controls the block through a single 32-bit control word on a plain write/read register port. A 4-bit select field picks the divide ratio from a fixed table that is not linear: ten codes are legal and they give ratios between 3 and 48. A separate stop bit holds the output low.

Software writes the control word at any time. A new ratio, and any change of the stop bit, is applied only at the end of the output period in progress. At that point the output is low, so the divided clock never shows a shortened high or low phase. A write that carries an unassigned select code leaves the ratio that was already stored unchanged. The stop bit in the same write still takes effect.

Top module: `tbl_clk_div`

## Requirements
- R1: After reset the control word reads 0x0000_0001 (select code 1, stop bit 0), the output is low while reset is held, and after reset the output runs with a period of 3 parent cycles.
- R2: Select codes map to output periods, in parent cycles, as follows: 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48.
- R3: A write whose select code is 0, 9, 12, 13, 14 or 15 leaves the stored select code and the output period unchanged.
- R4: While the stop bit (bit 8) is 1 the output stays low. Writing it back to 0 restarts the output at the stored ratio.
- R5: Reading offset 0x25C returns the select code in bits [3:0] and the stop bit in bit 8, with every other bit 0. Reads at any other offset return 0, and writes at any other offset change nothing.
- R6: For ratio N the output is high for floor(N/2) parent cycles and low for the rest of the period, so an odd ratio is high one cycle less than it is low.
- R7: A ratio written during a period takes effect only at the end of that period. The period in progress keeps the old length, and the next period has the new length.
- R8: Setting the stop bit while the output is high does not cut that high phase short. Stopping happens at the period boundary, and no rising edge follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent (fast) clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the offset on bus_addr |
| clk_out | output | 1 | Divided, gateable output clock |

## Verification
The bench builds the block with its default parameters: a 12-bit offset, the control word at 0x25C, the stop bit at position 8, select code 1 after reset, and a 6-bit ratio counter. These values cover every legal code up to the largest ratio of 48, and every unassigned code, in a few thousand parent cycles. Output periods and high times are measured from the edge times of the output. This also exposes mid-period ratio changes and the last high phase before the output stops.

// File: rtl/tcgd_pkg.sv
package tcgd_pkg;

    localparam int SEL_W   = 4;
    localparam int RATIO_W = 6;

    typedef logic [SEL_W-1:0]   sel_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        logic stop;
        sel_t sel;
    } ctrl_t;

    // Non-linear select table; 0 marks an unassigned code.
    function automatic ratio_t sel_to_ratio(input sel_t s);
        ratio_t r;
        case (s)
            4'd1:    r = ratio_t'(3);
            4'd2:    r = ratio_t'(4);
            4'd3:    r = ratio_t'(6);
            4'd4:    r = ratio_t'(8);
            4'd5:    r = ratio_t'(12);
            4'd6:    r = ratio_t'(16);
            4'd7:    r = ratio_t'(18);
            4'd8:    r = ratio_t'(24);
            4'd10:   r = ratio_t'(36);
            4'd11:   r = ratio_t'(48);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic sel_legal(input sel_t s);
        return sel_to_ratio(s) != '0;
    endfunction

endpackage

// File: rtl/tcgd_regs.sv
module tcgd_regs
    import tcgd_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [11:0] OFFSET   = 12'h25C,
    parameter int          SEL_LSB  = 0,
    parameter int          STOP_BIT = 8,
    parameter int          RST_SEL  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl
);
    localparam logic [ADDR_W-1:0] HIT = ADDR_W'(OFFSET);

    ctrl_t ctrl_q;
    sel_t  wr_sel;
    logic  hit;
    logic [DATA_W-1:0] word;

    assign hit    = (addr == HIT);
    assign wr_sel = wdata[SEL_LSB +: SEL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.stop <= 1'b0;
            ctrl_q.sel  <= sel_t'(RST_SEL);
        end else if (we && hit) begin
            ctrl_q.stop <= wdata[STOP_BIT];
            if (sel_legal(wr_sel)) begin
                ctrl_q.sel <= wr_sel;
            end
        end
    end

    always_comb begin
        word                        = '0;
        word[SEL_LSB +: SEL_W]      = ctrl_q.sel;
        word[STOP_BIT]              = ctrl_q.stop;
        rdata                       = hit ? word : '0;
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/tcgd_decode.sv
module tcgd_decode
    import tcgd_pkg::*;
(
    input  sel_t   sel,
    output ratio_t ratio
);
    assign ratio = sel_to_ratio(sel);
endmodule

// File: rtl/tcgd_core.sv
module tcgd_core
    import tcgd_pkg::*;
#(
    parameter int RST_RATIO = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  ratio_t ratio_in,
    input  logic   stop_in,
    output logic   clk_out,
    output ratio_t cnt_o,
    output ratio_t act_o,
    output logic   run_o
);
    localparam ratio_t ONE  = ratio_t'(1);
    localparam ratio_t R_RST = ratio_t'(RST_RATIO);

    ratio_t cnt_q, cnt_d, act_q, act_d;
    logic   run_q, run_d, out_q, out_d, wrap;

    assign wrap = (cnt_q == act_q - ONE);

    always_comb begin
        if (wrap) begin
            cnt_d = '0;
            act_d = ratio_in;
            run_d = ~stop_in;
        end else begin
            cnt_d = cnt_q + ONE;
            act_d = act_q;
            run_d = run_q;
        end
        out_d = run_d && (cnt_d < (act_d >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= R_RST - ONE;
            act_q <= R_RST;
            run_q <= 1'b1;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            act_q <= act_d;
            run_q <= run_d;
            out_q <= out_d;
        end
    end

    assign clk_out = out_q;
    assign cnt_o   = cnt_q;
    assign act_o   = act_q;
    assign run_o   = run_q;
endmodule

// File: rtl/tbl_clk_div.sv
module tbl_clk_div
    import tcgd_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [11:0] OFFSET   = 12'h25C,
    parameter int          SEL_LSB  = 0,
    parameter int          STOP_BIT = 8,
    parameter int          RST_SEL  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              clk_out
);
    localparam int RST_RATIO = int'(sel_to_ratio(sel_t'(RST_SEL)));

    ctrl_t  ctrl;
    ratio_t ratio;
    ratio_t cnt;
    ratio_t act;
    logic   run;

    tcgd_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET),
        .SEL_LSB(SEL_LSB), .STOP_BIT(STOP_BIT), .RST_SEL(RST_SEL)
    ) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .ctrl(ctrl)
    );

    tcgd_decode u_dec (
        .sel(ctrl.sel), .ratio(ratio)
    );

    tcgd_core #(.RST_RATIO(RST_RATIO)) u_core (
        .clk(clk), .rst(rst), .ratio_in(ratio), .stop_in(ctrl.stop),
        .clk_out(clk_out), .cnt_o(cnt), .act_o(act), .run_o(run)
    );
endmodule

// File: rtl/tcgd_checker.sv
module tcgd_checker
    import tcgd_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter int          DATA_W = 32,
    parameter logic [11:0] OFFSET = 12'h25C
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              clk_out,
    input sel_t              sel,
    input ratio_t            cnt,
    input ratio_t            act,
    input logic              run
);
    localparam logic [ADDR_W-1:0] HIT = ADDR_W'(OFFSET);

    p_act_legal_r2: assert property (@(posedge clk) disable iff (rst)
        act inside {6'd3, 6'd4, 6'd6, 6'd8, 6'd12, 6'd16, 6'd18, 6'd24, 6'd36, 6'd48});

    p_sel_kept_legal_r3: assert property (@(posedge clk) disable iff (rst)
        sel_legal(sel));

    p_stopped_low_r4: assert property (@(posedge clk) disable iff (rst)
        !run |-> !clk_out);

    p_other_offset_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != HIT) |-> (bus_rdata == '0));

    p_ratio_held_midperiod_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(act));

    p_run_held_midperiod_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(run));

    p_low_at_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt == act - ratio_t'(1)) |-> !clk_out);
endmodule

bind tbl_clk_div tcgd_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .clk_out(clk_out), .sel(ctrl.sel), .cnt(cnt), .act(act), .run(run)
);

// File: tb/tbl_clk_div_test.sv
module tbl_clk_div_test;
    localparam int CLK_P = 10;
    localparam logic [11:0] CTRL = 12'h25C;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_we = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct { int per; int hi; string tag; } exp_t;
    exp_t q[$];

    always #(CLK_P/2) clk = ~clk;

    tbl_clk_div uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_out(clk_out)
    );

    function automatic int ref_ratio(input int c);
        case (c)
            1: return 3;   2: return 4;   3: return 6;   4: return 8;
            5: return 12;  6: return 16;  7: return 18;  8: return 24;
            10: return 36; 11: return 48;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: measures each output period and its high time from edge times.
    longint last_rise = -1, last_fall = -1;
    int     rise_n = 0;
    bit     started = 0;
    always @(negedge clk_out) last_fall = $time;
    always @(posedge clk_out) begin
        if (started && q.size() > 0) begin
            exp_t e;
            longint per, hi;
            e   = q.pop_front();
            per = ($time - last_rise) / CLK_P;
            hi  = (last_fall - last_rise) / CLK_P;
            chk(per == e.per, e.tag, per, e.per);
            chk(hi == e.hi, "R6 high time", hi, e.hi);
            if (q.size() == 0) started = 0;
        end else if (q.size() > 0) begin
            started = 1;
        end
        last_rise = $time;
        rise_n++;
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_addr = '0;
    endtask

    // Driver: let the new setting settle, then queue the periods it must produce.
    task automatic expect_periods(input int n, input int ratio, input string tag);
        @(posedge clk_out);
        @(posedge clk_out);
        for (int i = 0; i < n; i++) q.push_back('{per: ratio, hi: ratio / 2, tag: tag});
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        longint t0, r1, r2;
        int rn;
        int bad_hi;

        repeat (5) @(negedge clk);
        chk(clk_out == 1'b0, "R1 output low in reset", clk_out, 0);
        rst = 0;

        // R1: reset value and default ratio
        bus_read(CTRL, rd);
        chk(rd == 32'h1, "R1 reset readback", rd, 32'h1);
        expect_periods(3, 3, "R1 reset period");

        // R2 / R5: every legal code
        for (int c = 1; c < 12; c++) begin
            if (ref_ratio(c) != 0) begin
                bus_write(CTRL, 32'(c));
                bus_read(CTRL, rd);
                chk(rd == 32'(c), "R5 select readback", rd, c);
                expect_periods(3, ref_ratio(c), "R2 period");
            end
        end

        // R3: unassigned codes keep ratio 8 (code 4)
        bus_write(CTRL, 32'h4);
        expect_periods(2, 8, "R2 period");
        for (int c = 0; c < 16; c++) begin
            if (ref_ratio(c) == 0) begin
                bus_write(CTRL, 32'(c));
                bus_read(CTRL, rd);
                chk(rd == 32'h4, "R3 unassigned code readback", rd, 4);
            end
        end
        expect_periods(3, 8, "R3 period unchanged");

        // R5: foreign offset ignored and reads zero
        bus_write(12'h270, 32'h1);
        bus_read(CTRL, rd);
        chk(rd == 32'h4, "R5 foreign write ignored", rd, 4);
        bus_read(12'h270, rd);
        chk(rd == 32'h0, "R5 foreign read zero", rd, 0);
        bus_write(CTRL, 32'hFFFF_FEF4);
        bus_read(CTRL, rd);
        chk(rd == 32'h4, "R5 only defined bits read back", rd, 4);
        expect_periods(2, 8, "R5 period unchanged");

        // R7: change ratio 8 -> 3 mid-period
        @(posedge clk_out);
        t0 = $time;
        bus_write(CTRL, 32'h1);
        @(posedge clk_out); r1 = $time;
        @(posedge clk_out); r2 = $time;
        chk((r1 - t0) / CLK_P == 8, "R7 current period keeps old ratio", (r1 - t0) / CLK_P, 8);
        chk((r2 - r1) / CLK_P == 3, "R7 next period uses new ratio", (r2 - r1) / CLK_P, 3);

        // R8 / R4: stop during high phase at ratio 48
        bus_write(CTRL, 32'hB);
        expect_periods(1, 48, "R2 period");
        @(posedge clk_out);
        t0 = $time;
        bus_write(CTRL, 32'h10B);
        repeat (150) @(negedge clk);
        chk(last_rise == t0, "R8 no rise after stop", last_rise, t0);
        chk((last_fall - last_rise) / CLK_P == 24, "R8 last high phase intact",
            (last_fall - last_rise) / CLK_P, 24);
        rn = rise_n;
        bad_hi = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (clk_out) bad_hi++;
        end
        chk(bad_hi == 0, "R4 output low while stopped", bad_hi, 0);
        chk(rise_n == rn, "R4 no edges while stopped", rise_n, rn);
        bus_read(CTRL, rd);
        chk(rd == 32'h10B, "R5 stop bit readback", rd, 32'h10B);

        // R4: restart
        bus_write(CTRL, 32'h6);
        expect_periods(3, 16, "R4 restart period");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule